// File: doc/BRIEF.md
# Ethernet Serial Receive Framer

This block sits behind a line decoder and turns a recovered bit-serial receive stream into octets. The decoder supplies one data bit per strobe on the system clock, plus a carrier-sense level and a collision indication. While carrier sense is high the framer hunts through the alternating preamble for the start-of-frame delimiter, two consecutive 1 bits. Once it has found the delimiter it packs every following bit into octets, least significant bit first, and pushes each finished octet into a small receive FIFO. A serial CRC-32 runs over every bit after the delimiter.

When carrier sense drops, the framer closes the frame. For one cycle it raises an end-of-frame strobe, together with a status word that flags alignment error, CRC error, runt length, FIFO overrun and collision. It also flags rejection, which applies when the reject-on-error option is on and any of those conditions is present. An address filter upstream can stop octets from being written to the FIFO by holding its accept input low. A consumer drains the FIFO through a simple pop interface.

Top module: `eth_rx_framer`

## Requirements
- R1: No octet is written into the FIFO until two consecutive 1 bits have been strobed while crs_i is high. Whenever crs_i is low, the hunt restarts with no memory of earlier bits.
- R2: After the delimiter, each group of 8 strobed bits forms one octet, with the first bit received in bit 0. Octets leave the FIFO (depth 32) in arrival order on fifo_data_o while fifo_valid_o is high. A high fifo_rd_i pops the head.
- R3: eof_o is high for exactly one cycle. That cycle directly follows the clock edge at which crs_i is sampled low during a frame. status_o is valid in the same cycle. Loss of carrier before a delimiter produces no eof_o.
- R4: status_o bit 0 (alignment) is set when the number of bits strobed after the delimiter is not a multiple of 8.
- R5: status_o bit 1 (CRC) is set when the CRC-32 register does not hold 0xC704DD7B at end of frame. The register uses polynomial 0x04C11DB7, starts at all ones, shifts towards the MSB, and covers every bit after the delimiter, FCS included.
- R6: status_o bit 2 (runt) is set when fewer than 64 complete octets, FCS included, were received.
- R7: status_o bit 3 (overrun) is set when an octet completes while the FIFO holds 32 entries and is not being popped. That octet is dropped and the stored octets are kept.
- R8: An octet that completes while addr_accept_i is low is not written. This does not alter status_o.
- R9: status_o bit 4 is set if col_i was high at any cycle of the frame. Bit 5 (rejected) equals reject_bad_i ANDed with the OR of bits 0 to 4.
- R10: After reset, eof_o and fifo_valid_o are low and status_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Recovered serial data bit |
| rx_valid_i | input | 1 | Strobe: rx_bit_i holds a new bit |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision detected on the medium |
| addr_accept_i | input | 1 | Address filter verdict; low suppresses FIFO writes |
| reject_bad_i | input | 1 | Reject frames that saw any error or collision |
| fifo_rd_i | input | 1 | Pop the FIFO head |
| fifo_data_o | output | 8 | FIFO head octet |
| fifo_valid_o | output | 1 | FIFO not empty |
| eof_o | output | 1 | End-of-frame strobe |
| status_o | output | 6 | End-of-frame status: {rejected, collision, overrun, runt, crc, align} |

## Verification
Several properties are checked on every cycle by the assertions. The FIFO occupancy never grows while the framer is hunting or while the filter rejects. An end-of-frame strobe always follows loss of carrier inside a frame and never lasts two cycles. A write into a full FIFO leaves the occupancy unchanged. Other behaviours appear only in the bench's directed frames: the octet contents and their bit order, the classification of CRC, runt, alignment, overrun and collision, the reject rule, and the restart of the hunt after a carrier gap.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

  typedef struct packed {
    logic rejected;
    logic collision;
    logic overrun;
    logic runt;
    logic crc_err;
    logic align_err;
  } rx_status_t;

  function automatic logic [31:0] crc_step(input logic [31:0] crc, input logic b);
    logic fb;
    fb = crc[31] ^ b;
    return {crc[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
  endfunction
endpackage

// File: rtl/eth_rx_sfd_det.sv
module eth_rx_sfd_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic sfd_o
);
  logic prev_q;

  assign sfd_o = en_i && bit_i && prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b0;
    else if (clr_i)  prev_q <= 1'b0;
    else if (en_i)   prev_q <= bit_i;
  end
endmodule

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
  import eth_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic en_i,
  input  logic bit_i,
  output logic match_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (init_i) crc_q <= CRC_INIT;
    else if (en_i)   crc_q <= crc_step(crc_q, bit_i);
  end

  assign match_o = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/eth_rx_fifo.sv
module eth_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             wr_ready_o,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             valid_o,
  output logic [CW-1:0]    cnt_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_wr, do_rd;

  assign valid_o    = (cnt_q != '0);
  assign do_rd      = rd_i && valid_o;
  assign wr_ready_o = (cnt_q != CW'(DEPTH)) || do_rd;
  assign do_wr      = wr_i && wr_ready_o;
  assign rdata_o    = mem_q[rptr_q];
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (do_rd) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
    end
  end

  // R7: a write into a full FIFO with no pop leaves the occupancy unchanged
  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(DEPTH) && wr_i && !rd_i) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/eth_rx_framer.sv
module eth_rx_framer
  import eth_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int MIN_OCTETS = 64,
  localparam int CW = $clog2(FIFO_DEPTH + 1),
  localparam int BW = $clog2(MIN_OCTETS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_bit_i,
  input  logic       rx_valid_i,
  input  logic       crs_i,
  input  logic       col_i,
  input  logic       addr_accept_i,
  input  logic       reject_bad_i,
  input  logic       fifo_rd_i,
  output logic [7:0] fifo_data_o,
  output logic       fifo_valid_o,
  output logic       eof_o,
  output logic [5:0] status_o
);
  logic          in_frame_q;
  logic [2:0]    bit_cnt_q;
  logic [BW-1:0] oct_cnt_q;
  logic [6:0]    sr_q;
  logic          ovr_q, col_q, eof_q;
  rx_status_t    st_q, st_d;

  logic          hunt_en, sfd, bit_en, oct_done, wr, wr_ready, crc_ok;
  logic [CW-1:0] fifo_cnt;

  assign hunt_en  = crs_i && !in_frame_q && rx_valid_i;
  assign bit_en   = crs_i && in_frame_q && rx_valid_i;
  assign oct_done = bit_en && (bit_cnt_q == 3'd7);
  assign wr       = oct_done && addr_accept_i;

  eth_rx_sfd_det u_sfd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!crs_i),
    .en_i   (hunt_en),
    .bit_i  (rx_bit_i),
    .sfd_o  (sfd)
  );

  eth_rx_crc u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (sfd),
    .en_i    (bit_en),
    .bit_i   (rx_bit_i),
    .match_o (crc_ok)
  );

  eth_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .wdata_i    ({rx_bit_i, sr_q}),
    .wr_ready_o (wr_ready),
    .rd_i       (fifo_rd_i),
    .rdata_o    (fifo_data_o),
    .valid_o    (fifo_valid_o),
    .cnt_o      (fifo_cnt)
  );

  always_comb begin
    st_d.align_err = (bit_cnt_q != 3'd0);
    st_d.crc_err   = !crc_ok;
    st_d.runt      = (oct_cnt_q < BW'(MIN_OCTETS));
    st_d.overrun   = ovr_q;
    st_d.collision = col_q || col_i;
    st_d.rejected  = reject_bad_i && (st_d.align_err || st_d.crc_err || st_d.runt ||
                                      st_d.overrun || st_d.collision);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      bit_cnt_q  <= '0;
      oct_cnt_q  <= '0;
      sr_q       <= '0;
      ovr_q      <= 1'b0;
      col_q      <= 1'b0;
      eof_q      <= 1'b0;
      st_q       <= '0;
    end else begin
      eof_q <= 1'b0;
      if (!crs_i) begin
        if (in_frame_q) begin
          eof_q <= 1'b1;
          st_q  <= st_d;
        end
        in_frame_q <= 1'b0;
      end else if (!in_frame_q) begin
        if (sfd) begin
          in_frame_q <= 1'b1;
          bit_cnt_q  <= '0;
          oct_cnt_q  <= '0;
          ovr_q      <= 1'b0;
          col_q      <= 1'b0;
        end
      end else begin
        if (col_i) col_q <= 1'b1;
        if (bit_en) begin
          sr_q      <= {rx_bit_i, sr_q[6:1]};
          bit_cnt_q <= bit_cnt_q + 3'd1;
        end
        if (oct_done && oct_cnt_q != BW'(MIN_OCTETS)) oct_cnt_q <= oct_cnt_q + 1'b1;
        if (wr && !wr_ready) ovr_q <= 1'b1;
      end
    end
  end

  assign eof_o    = eof_q;
  assign status_o = st_q;

  a_r1_no_write_in_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_frame_q |=> (fifo_cnt <= $past(fifo_cnt)));
  a_r8_filter_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_accept_i |=> (fifo_cnt <= $past(fifo_cnt)));
  a_r3_eof_after_carrier_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_q && !crs_i) |=> eof_o);
  a_r3_eof_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);
endmodule

// File: tb/eth_rx_framer_test.sv
module eth_rx_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0, rx_valid = 1'b0, crs = 1'b0, col = 1'b0;
  logic addr_acc = 1'b1, rej_bad = 1'b0, fifo_rd = 1'b0;
  logic [7:0] fifo_data;
  logic fifo_valid, eof;
  logic [5:0] status;

  int n_chk = 0, n_err = 0;
  logic [7:0] fr [0:127];
  int fr_len;
  logic [7:0] rxq [0:255];
  int rx_n = 0;
  int eof_n = 0;
  logic [5:0] last_st;
  logic drain = 1'b1;

  always #5ns clk = ~clk;

  eth_rx_framer uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .rx_valid_i(rx_valid),
    .crs_i(crs), .col_i(col), .addr_accept_i(addr_acc), .reject_bad_i(rej_bad),
    .fifo_rd_i(fifo_rd), .fifo_data_o(fifo_data), .fifo_valid_o(fifo_valid),
    .eof_o(eof), .status_o(status)
  );

  initial forever begin
    @(negedge clk);
    if (drain && fifo_valid) begin
      rxq[rx_n] = fifo_data;
      rx_n++;
      fifo_rd = 1'b1;
    end else begin
      fifo_rd = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (eof) begin
      eof_n++;
      last_st = status;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic b);
    return (c[31] ^ b) ? ({c[30:0], 1'b0} ^ 32'h04C11DB7) : {c[30:0], 1'b0};
  endfunction

  task automatic build(input int npay, input int seed);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < npay; i++) begin
      fr[i] = (i == 0) ? 8'h01 : 8'((i * 37 + seed) ^ (i >> 1));
      for (int j = 0; j < 8; j++) c = crc_bit(c, fr[i][j]);
    end
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 8; j++) fr[npay + k][j] = ~c[31 - (8 * k + j)];
    fr_len = npay + 4;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(input int extra_bits, input int col_at);
    crs = 1'b1;
    for (int i = 0; i < 6; i++) begin send_bit(1'b1); send_bit(1'b0); end
    send_bit(1'b1); send_bit(1'b1);
    for (int i = 0; i < fr_len; i++) begin
      if (i == col_at) begin @(negedge clk); col = 1'b1; @(negedge clk); col = 1'b0; end
      for (int j = 0; j < 8; j++) send_bit(fr[i][j]);
    end
    for (int i = 0; i < extra_bits; i++) send_bit(i[0] ? 1'b0 : 1'b1);
    @(negedge clk);
    crs = 1'b0;
  endtask

  task automatic finish_frame(input string req);
    int e0;
    e0 = eof_n;
    @(negedge clk);
    check(eof === 1'b1, req, int'(eof), 1);
    @(negedge clk);
    check(eof === 1'b0, req, int'(eof), 0);
    repeat (40) @(negedge clk);
    check(eof_n == e0 + 1, req, eof_n - e0, 1);
  endtask

  task automatic check_bytes(input int n, input string req);
    check(rx_n == n, req, rx_n, n);
    for (int i = 0; i < n && i < rx_n; i++)
      if (rxq[i] !== fr[i]) begin check(1'b0, req, int'(rxq[i]), int'(fr[i])); return; end
    check(1'b1, req, 0, 0);
  endtask

  task automatic t_reset();
    check(eof === 1'b0, "R10 eof", int'(eof), 0);
    check(fifo_valid === 1'b0, "R10 fifo_valid", int'(fifo_valid), 0);
    check(status === 6'h0, "R10 status", int'(status), 0);
  endtask

  task automatic t_good();
    build(60, 3); rx_n = 0;
    send_frame(0, -1);
    finish_frame("R3 good eof");
    check(last_st == 6'h00, "R5 R6 good status", int'(last_st), 0);
    check(rxq[0] == 8'h01, "R2 lsb first", int'(rxq[0]), 1);
    check_bytes(64, "R2 R1 good bytes");
  endtask

  task automatic t_runt();
    build(16, 9); rx_n = 0;
    send_frame(0, -1);
    finish_frame("R6 runt eof");
    check(last_st == 6'h04, "R6 runt status", int'(last_st), 4);
    check_bytes(20, "R6 runt bytes");
  endtask

  task automatic t_crc();
    build(60, 5);
    fr[10][3] = ~fr[10][3];
    rx_n = 0;
    send_frame(0, -1);
    finish_frame("R5 crc eof");
    check(last_st == 6'h02, "R5 crc status", int'(last_st), 2);
  endtask

  task automatic t_align();
    build(60, 7); rx_n = 0;
    send_frame(3, -1);
    finish_frame("R4 align eof");
    check(last_st[0] == 1'b1 && last_st[2] == 1'b0, "R4 align status", int'(last_st), 1);
    check_bytes(64, "R4 align bytes");
  endtask

  task automatic t_overrun();
    build(60, 11); rx_n = 0;
    drain = 1'b0;
    send_frame(0, -1);
    finish_frame("R7 overrun eof");
    check(last_st == 6'h08, "R7 overrun status", int'(last_st), 8);
    drain = 1'b1;
    repeat (50) @(negedge clk);
    check_bytes(32, "R7 kept bytes");
  endtask

  task automatic t_filter();
    build(60, 13); rx_n = 0;
    addr_acc = 1'b0;
    send_frame(0, -1);
    finish_frame("R8 filter eof");
    addr_acc = 1'b1;
    check(rx_n == 0, "R8 no writes", rx_n, 0);
    check(last_st == 6'h00, "R8 status", int'(last_st), 0);
  endtask

  task automatic t_collision();
    build(60, 17); rx_n = 0;
    rej_bad = 1'b0;
    send_frame(0, 5);
    finish_frame("R9 col eof");
    check(last_st == 6'h10, "R9 collision no reject", int'(last_st), 16);
    rej_bad = 1'b1;
    send_frame(0, 20);
    finish_frame("R9 col reject eof");
    check(last_st == 6'h30, "R9 collision reject", int'(last_st), 48);
    send_frame(0, -1);
    finish_frame("R9 good reject_bad eof");
    check(last_st == 6'h00, "R9 good not rejected", int'(last_st), 0);
    build(16, 19);
    send_frame(0, -1);
    finish_frame("R9 runt reject eof");
    check(last_st == 6'h24, "R9 runt rejected", int'(last_st), 36);
    rej_bad = 1'b0;
  endtask

  task automatic t_hunt();
    int e0;
    e0 = eof_n; rx_n = 0;
    crs = 1'b1;
    for (int i = 0; i < 5; i++) begin send_bit(1'b1); send_bit(1'b0); end
    send_bit(1'b1);
    @(negedge clk); crs = 1'b0;
    repeat (4) @(negedge clk);
    check(eof_n == e0, "R3 R1 no eof without sfd", eof_n - e0, 0);
    check(rx_n == 0, "R1 no data without sfd", rx_n, 0);
    build(60, 23);
    send_frame(0, -1);
    finish_frame("R1 hunt restart eof");
    check(last_st == 6'h00, "R1 restart status", int'(last_st), 0);
    check_bytes(64, "R1 restart bytes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_good();
    t_runt();
    t_crc();
    t_align();
    t_overrun();
    t_filter();
    t_collision();
    t_hunt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #1ms;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule